// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block drives the bus cycles an 8-bit processor core needs to enter and leave its exception handlers. It starts a sequence when the processor reset input is released, when a falling edge appears on the non-maskable interrupt line, or when the maskable request line is low while the interrupt-disable bit of the status byte is clear. It also runs the return-from-interrupt sequence when the core asks for one. Interrupts are taken only when the core signals an instruction boundary. On entry the block saves the return address and the status byte on a downward-growing hardware stack in page one, then reads a little-endian two-byte vector from the top of memory. It hands the new program counter and status byte back to the core with a one-cycle completion pulse.

The core supplies its current program counter and status byte at the boundary. Memory is on a plain bus: an address, write data, a write enable, and read data that is valid in the same cycle the address is driven. Instruction decode and arithmetic stay in the core.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low the block is busy and never writes. After release it runs 7 busy cycles with no stack writes and lowers the stack pointer from 0x00 to 0xFD. It then loads `pc_o` = {byte at 0xFFFD, byte at 0xFFFC} and `p_o` = 0x04.
- R2: Every write the block makes targets an address whose upper byte is 0x01 and whose lower byte is the stack pointer.
- R3: An interrupt entry with stack pointer S writes the return address high byte at 0x01:S, the low byte at 0x01:S-1 and the status byte at 0x01:S-2. It leaves `sp_o` = S-3, so each push writes first and decrements after.
- R4: A high-to-low change on `nmi_n` is remembered, including one that arrives during a sequence, and is taken at the next boundary whatever the status bit 2. It loads `pc_o` = {[0xFFFB],[0xFFFA]}. A line held low causes one entry only.
- R5: A low `irq_n` is taken at a boundary only when `p_in` bit 2 (interrupt disable) is 0. It loads `pc_o` = {[0xFFFF],[0xFFFE]}. With bit 2 set, nothing starts.
- R6: A sequence starts only when the block is idle and `insn_done` is high. `insn_done` and `rti_req` have no effect while `busy` is high.
- R7: An interrupt entry keeps `busy` high for exactly 7 cycles. `seq_done` pulses in the first idle cycle, and `p_o` equals the saved status with bit 2 set.
- R8: A return keeps `busy` high for exactly 6 cycles. It pulls the status, then the low address byte, then the high address byte, incrementing the stack pointer before each read. It restores `pc_o`, `p_o` and `sp_o` to their values from before the matching entry.
- R9: When several requests meet at one boundary, a pending NMI wins over IRQ, and IRQ wins over a return request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Processor reset, active low, synchronous; its release starts the reset sequence |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active low level |
| insn_done | input | 1 | Core is at an instruction boundary |
| rti_req | input | 1 | Core requests the return-from-interrupt sequence |
| ret_pc | input | 16 | Core program counter to save at the boundary |
| p_in | input | 8 | Core status byte; bit 2 is interrupt disable |
| mem_rdata | input | 8 | Read data, valid in the cycle the address is driven |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Bus write enable |
| busy | output | 1 | A sequence or reset is in progress |
| seq_done | output | 1 | One-cycle pulse: `pc_o` and `p_o` hold new values |
| pc_o | output | 16 | Program counter for the core to resume from |
| p_o | output | 8 | Status byte for the core to adopt |
| sp_o | output | 8 | Stack pointer low byte |

## Verification
The assertions check several rules on every cycle. Writes stay in page one, each write is followed by a stack pointer decrement, the idle state neither writes nor moves the stack pointer, and the completion pulse lasts one cycle at the exact end of a sequence while the results hold steady between pulses. Cycle counts, push order, vector choice, masking, edge memory, priority and the round trip through entry and return need the bench's scenarios. The bench sweeps many return-address and status patterns through entry and return pairs and compares the stack contents and the restored values with arithmetic expectations.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int I_BIT  = 2;
    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE;
    localparam logic [DATA_W-1:0] I_MASK     = 8'(1 << I_BIT);

    typedef enum logic [3:0] {
        ST_HOLD, ST_IDLE,
        ST_E1, ST_E2, ST_E3, ST_E4, ST_E5, ST_E6, ST_E7,
        ST_R1, ST_R2, ST_R3, ST_R4, ST_R5, ST_R6
    } state_e;

    typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ, K_RTI} kind_e;

    typedef struct packed {
        state_e              st;
        kind_e               kind;
        logic [DATA_W-1:0]   sp;
        logic [ADDR_W-1:0]   ret;
        logic [DATA_W-1:0]   p;
        logic [DATA_W-1:0]   lo;
        logic [DATA_W-1:0]   hi;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   pout;
        logic                done;
    } regs_t;
endpackage

// File: rtl/irqseq_nmi_latch.sv
module irqseq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pending
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d.prev = nmi_n;
        e_d.pend = (e_q.pend & ~take) | (e_q.prev & ~nmi_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q.prev <= nmi_n;
            e_q.pend <= 1'b0;
        end else begin
            e_q <= e_d;
        end
    end

    assign pending = e_q.pend;
endmodule

// File: rtl/irqseq_arbiter.sv
module irqseq_arbiter
    import irqseq_pkg::*;
(
    input  logic  idle,
    input  logic  insn_done,
    input  logic  nmi_pend,
    input  logic  irq_n,
    input  logic  i_flag,
    input  logic  rti_req,
    output logic  start,
    output logic  nmi_take,
    output kind_e kind
);
    logic irq_ok;
    logic at_bound;

    always_comb begin
        irq_ok   = ~irq_n & ~i_flag;
        at_bound = idle & insn_done;
        start    = at_bound & (nmi_pend | irq_ok | rti_req);
        nmi_take = at_bound & nmi_pend;
        if (nmi_pend)    kind = K_NMI;
        else if (irq_ok) kind = K_IRQ;
        else             kind = K_RTI;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irqseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nmi_n,
    input  logic        irq_n,
    input  logic        insn_done,
    input  logic        rti_req,
    input  logic [15:0] ret_pc,
    input  logic [7:0]  p_in,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        busy,
    output logic        seq_done,
    output logic [15:0] pc_o,
    output logic [7:0]  p_o,
    output logic [7:0]  sp_o
);
    localparam regs_t REGS_RST = '{
        st: ST_HOLD, kind: K_RST, sp: '0, ret: '0, p: '0,
        lo: '0, hi: '0, pc: '0, pout: '0, done: 1'b0
    };

    regs_t r_d, r_q;

    logic              nmi_pend;
    logic              nmi_take;
    logic              start;
    kind_e             start_kind;
    logic [ADDR_W-1:0] vec_a;
    logic [ADDR_W-1:0] stk_a;
    logic [ADDR_W-1:0] stk_up_a;

    irqseq_nmi_latch i_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .take    (nmi_take),
        .pending (nmi_pend)
    );

    irqseq_arbiter i_arb (
        .idle      (r_q.st == ST_IDLE),
        .insn_done (insn_done),
        .nmi_pend  (nmi_pend),
        .irq_n     (irq_n),
        .i_flag    (p_in[I_BIT]),
        .rti_req   (rti_req),
        .start     (start),
        .nmi_take  (nmi_take),
        .kind      (start_kind)
    );

    always_comb begin
        case (r_q.kind)
            K_NMI:   vec_a = VEC_NMI;
            K_IRQ:   vec_a = VEC_IRQ;
            default: vec_a = VEC_RST;
        endcase
        stk_a    = {STACK_PAGE, r_q.sp};
        stk_up_a = {STACK_PAGE, r_q.sp + 8'd1};
    end

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_addr  = r_q.ret;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (r_q.st)
            ST_HOLD: r_d.st = ST_E1;
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = (start_kind == K_RTI) ? ST_R1 : ST_E1;
                    r_d.kind = start_kind;
                    r_d.ret  = ret_pc;
                    r_d.p    = p_in;
                end
            end
            ST_E1: r_d.st = ST_E2;
            ST_E2: r_d.st = ST_E3;
            ST_E3: begin
                mem_addr  = stk_a;
                mem_we    = (r_q.kind != K_RST);
                mem_wdata = r_q.ret[15:8];
                r_d.sp    = r_q.sp - 8'd1;
                r_d.st    = ST_E4;
            end
            ST_E4: begin
                mem_addr  = stk_a;
                mem_we    = (r_q.kind != K_RST);
                mem_wdata = r_q.ret[7:0];
                r_d.sp    = r_q.sp - 8'd1;
                r_d.st    = ST_E5;
            end
            ST_E5: begin
                mem_addr  = stk_a;
                mem_we    = (r_q.kind != K_RST);
                mem_wdata = r_q.p;
                r_d.sp    = r_q.sp - 8'd1;
                r_d.st    = ST_E6;
            end
            ST_E6: begin
                mem_addr = vec_a;
                r_d.lo   = mem_rdata;
                r_d.st   = ST_E7;
            end
            ST_E7: begin
                mem_addr = vec_a | 16'd1;
                r_d.pc   = {mem_rdata, r_q.lo};
                r_d.pout = r_q.p | I_MASK;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            ST_R1: r_d.st = ST_R2;
            ST_R2: begin
                mem_addr = stk_a;
                r_d.st   = ST_R3;
            end
            ST_R3: begin
                mem_addr = stk_up_a;
                r_d.p    = mem_rdata;
                r_d.sp   = r_q.sp + 8'd1;
                r_d.st   = ST_R4;
            end
            ST_R4: begin
                mem_addr = stk_up_a;
                r_d.lo   = mem_rdata;
                r_d.sp   = r_q.sp + 8'd1;
                r_d.st   = ST_R5;
            end
            ST_R5: begin
                mem_addr = stk_up_a;
                r_d.hi   = mem_rdata;
                r_d.sp   = r_q.sp + 8'd1;
                r_d.st   = ST_R6;
            end
            ST_R6: begin
                mem_addr = {r_q.hi, r_q.lo};
                r_d.pc   = {r_q.hi, r_q.lo};
                r_d.pout = r_q.p;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign seq_done = r_q.done;
    assign pc_o     = r_q.pc;
    assign p_o      = r_q.pout;
    assign sp_o     = r_q.sp;
endmodule

// File: rtl/irqseq_checker.sv
module irqseq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        busy,
    input logic        seq_done,
    input logic [15:0] pc_o,
    input logic [7:0]  p_o,
    input logic [7:0]  sp_o
);
    p_page_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == 8'h01 && mem_addr[7:0] == sp_o));

    p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_o == $past(sp_o) - 8'd1));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    p_idle_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(sp_o));

    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> seq_done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!busy ##1 !seq_done));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done |-> ($stable(pc_o) && $stable(p_o)));
endmodule

bind irq_entry_seq irqseq_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .busy     (busy),
    .seq_done (seq_done),
    .pc_o     (pc_o),
    .p_o      (p_o),
    .sp_o     (sp_o)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n, nmi_n, irq_n, insn_done, rti_req;
    logic [15:0] ret_pc;
    logic [7:0]  p_in, mem_rdata;
    logic [15:0] mem_addr, pc_o;
    logic [7:0]  mem_wdata, p_o, sp_o;
    logic        mem_we, busy, seq_done;

    logic [7:0] stk [256];
    int total = 0;
    int bad = 0;
    int off_page = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .insn_done(insn_done), .rti_req(rti_req), .ret_pc(ret_pc), .p_in(p_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .busy(busy), .seq_done(seq_done), .pc_o(pc_o),
        .p_o(p_o), .sp_o(sp_o)
    );

    always_comb begin
        case (mem_addr)
            16'hFFFA: mem_rdata = 8'h34;
            16'hFFFB: mem_rdata = 8'h12;
            16'hFFFC: mem_rdata = 8'h00;
            16'hFFFD: mem_rdata = 8'h80;
            16'hFFFE: mem_rdata = 8'hCD;
            16'hFFFF: mem_rdata = 8'hAB;
            default:  mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : 8'hEA;
        endcase
    end

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
            else off_page <= off_page + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(output int n);
        n = 0;
        @(negedge clk);
        insn_done = 1'b0;
        rti_req   = 1'b0;
        while (busy && n < 40) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        int diff;
        logic [7:0]  sp0;
        logic [15:0] r;
        logic [7:0]  p;
        rst_n = 1'b0; nmi_n = 1'b1; irq_n = 1'b1; insn_done = 1'b0;
        rti_req = 1'b0; ret_pc = '0; p_in = '0;
        for (int i = 0; i < 256; i++) stk[i] = 8'(i) ^ 8'h5A;
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 1);
        chk("R1 no write in reset", 32'(mem_we), 0);

        // R1: release of reset
        rst_n = 1'b1;
        run(n);
        chk("R1 reset length", n, 7);
        chk("R1 done pulse", 32'(seq_done), 1);
        chk("R1 reset vector", 32'(pc_o), 32'h8000);
        chk("R1 status", 32'(p_o), 32'h04);
        chk("R1 sp", 32'(sp_o), 32'hFD);
        diff = 0;
        for (int i = 0; i < 256; i++) if (stk[i] !== (8'(i) ^ 8'h5A)) diff++;
        chk("R1 stack untouched", diff, 0);
        @(negedge clk);
        chk("R7 done is one cycle", 32'(seq_done), 0);

        // R3 R5 R7 R8: sweep of entry/return pairs
        for (int k = 0; k < 16; k++) begin
            r   = 16'h1357 * 16'(k + 1);
            p   = {4'(k), 4'b0001} ^ {4'b0, 4'(k) & 4'b1010};
            sp0 = sp_o;
            irq_n = 1'b0; p_in = p; ret_pc = r; insn_done = 1'b1;
            run(n);
            irq_n = 1'b1;
            chk("R7 entry length", n, 7);
            chk("R7 done", 32'(seq_done), 1);
            chk("R5 irq vector", 32'(pc_o), 32'hABCD);
            chk("R7 status I set", 32'(p_o), 32'(p | 8'h04));
            chk("R3 pch", 32'(stk[sp0]), 32'(r[15:8]));
            chk("R3 pcl", 32'(stk[8'(sp0 - 8'd1)]), 32'(r[7:0]));
            chk("R3 status", 32'(stk[8'(sp0 - 8'd2)]), 32'(p));
            chk("R3 sp", 32'(sp_o), 32'(8'(sp0 - 8'd3)));
            p_in = 8'hFF; ret_pc = 16'h0000; rti_req = 1'b1; insn_done = 1'b1;
            run(n);
            chk("R8 return length", n, 6);
            chk("R8 pc", 32'(pc_o), 32'(r));
            chk("R8 status", 32'(p_o), 32'(p));
            chk("R8 sp", 32'(sp_o), 32'(sp0));
        end

        // R5: masked
        sp0 = sp_o;
        irq_n = 1'b0; p_in = 8'h04; insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk("R5 masked no start", 32'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R5 masked still idle", 32'(busy), 0);
        chk("R5 masked sp", 32'(sp_o), 32'(sp0));

        // R6: no boundary, no start
        p_in = 8'h00;
        repeat (5) @(negedge clk);
        chk("R6 waits for boundary", 32'(busy), 0);

        // R6: boundary inputs ignored while busy
        ret_pc = 16'h2468; insn_done = 1'b1;
        @(negedge clk);
        n = 0;
        irq_n = 1'b1; rti_req = 1'b1;
        while (busy && n < 40) begin
            n++;
            if (n == 5) begin insn_done = 1'b0; rti_req = 1'b0; end
            @(negedge clk);
        end
        chk("R6 length with boundary held", n, 7);
        chk("R6 vector unchanged", 32'(pc_o), 32'hABCD);
        @(negedge clk);
        chk("R6 no second start", 32'(busy), 0);
        rti_req = 1'b1; insn_done = 1'b1;
        run(n);
        chk("R8 pc after held case", 32'(pc_o), 32'h2468);

        // R4: nmi edge, waits for boundary, ignores I
        p_in = 8'h04; nmi_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 waits for boundary", 32'(busy), 0);
        ret_pc = 16'h4321; insn_done = 1'b1;
        run(n);
        chk("R4 nmi length", n, 7);
        chk("R4 nmi vector", 32'(pc_o), 32'h1234);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk("R4 level gives one entry", 32'(busy), 0);
        nmi_n = 1'b1;
        @(negedge clk);

        // R4: edge during a sequence is remembered
        p_in = 8'h00; irq_n = 1'b0; insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0; irq_n = 1'b1;
        @(negedge clk);
        nmi_n = 1'b0;
        while (busy) @(negedge clk);
        chk("R5 irq before edge", 32'(pc_o), 32'hABCD);
        insn_done = 1'b1;
        run(n);
        chk("R4 edge held through sequence", 32'(pc_o), 32'h1234);
        nmi_n = 1'b1;
        @(negedge clk);

        // R9: priority
        nmi_n = 1'b0; irq_n = 1'b0; rti_req = 1'b1; p_in = 8'h00;
        @(negedge clk);
        insn_done = 1'b1; rti_req = 1'b1;
        run(n);
        chk("R9 nmi over irq and return", 32'(pc_o), 32'h1234);
        rti_req = 1'b1; insn_done = 1'b1;
        run(n);
        chk("R9 irq over return", 32'(pc_o), 32'hABCD);
        irq_n = 1'b1; nmi_n = 1'b1;
        rti_req = 1'b1; insn_done = 1'b1;
        run(n);
        chk("R9 return when alone", n, 6);

        chk("R2 writes outside page one", off_page, 0);
        summary();
        $finish;
    end
endmodule